// File: doc/BRIEF.md
# Vector Shift-and-Resize Unit

This block is a single-stage vector datapath that changes the width of SIMD lanes while shifting them. In widen mode it reads half a register's worth of narrow lanes, extends each one to twice its width (sign or zero extension), shifts the result left by an immediate and writes a full register of wide lanes. In narrow mode it reads a full register of wide lanes, shifts each one right logically by an immediate and keeps the low half of every lane. The narrow results fill one half of the output register.

A half-select bit picks which half takes part. A wide vector can therefore be processed in two passes. In widen mode the bit picks the upper or lower half of the source. In narrow mode it picks the output half: the lower half of the destination is either kept or the upper half is cleared. Operands go in with a valid strobe and the result comes out one clock later. An illegal lane size or an out-of-range immediate sets an error flag instead.

Top module: `vec_shift_resize`

## Requirements
- R1: Inputs are registered once. `out_valid` is `in_valid` delayed by one clock. `out_vec` and `out_err` change only on a cycle after `in_valid` was high and hold otherwise. Reset clears all outputs to zero.
- R2: `size_code` 0, 1 and 2 select a narrow lane width of 8, 16 and 32 bits. Each mode handles 64/width lanes (8, 4 or 2), and each wide lane is twice the narrow width.
- R3: In widen mode, `half_sel`=1 takes the source lanes from `src_vec[127:64]` and `half_sel`=0 takes them from `src_vec[63:0]`. Narrow lane i sits at bits [i*w +: w] of that half.
- R4: In widen mode, `sext`=1 sign-extends each source lane and `sext`=0 zero-extends it.
- R5: In widen mode, the extended lane is shifted left by `shamt` (legal range 0 to the narrow width, inclusive). It is truncated to 2w bits and written to `out_vec[i*2w +: 2w]`.
- R6: In narrow mode, wide lane i is `src_vec[i*2w +: 2w]`. It is shifted right logically by `shamt`, and its low w bits become narrow result lane i. `sext` has no effect in this mode.
- R7: In narrow mode with `half_sel`=1, the narrow lanes go to `out_vec[127:64]` and `out_vec[63:0]` equals `dst_keep`.
- R8: In narrow mode with `half_sel`=0, the narrow lanes go to `out_vec[63:0]` and `out_vec[127:64]` is zero.
- R9: `size_code`=3 is reserved. It sets `out_err`=1 and `out_vec`=0 in either mode.
- R10: An immediate outside its range sets `out_err`=1 and `out_vec`=0. For widen the legal range is 0 to w; for narrow it is 1 to w.
- R11: In widen mode `dst_keep` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| op_narrow | input | 1 | 0 = widen, 1 = narrow |
| src_vec | input | 128 | Source register |
| dst_keep | input | 64 | Lower half of the destination, kept by the upper-half narrow pass |
| size_code | input | 2 | Narrow lane width code (8 << code bits) |
| shamt | input | 7 | Immediate shift amount |
| sext | input | 1 | Sign-extend in widen mode |
| half_sel | input | 1 | Half select (widen source / narrow destination) |
| out_valid | output | 1 | Result strobe |
| out_err | output | 1 | Reserved size or immediate out of range |
| out_vec | output | 128 | Result register |

## Verification
The bench targets these corner cases, each with a distinct failure it would expose:
- Widen with a shift equal to the full narrow width. A design that saturates or masks the shift would drop the top source bit.
- Sign extension of negative lanes with non-zero shifts. Zero-filling here would corrupt the upper half of every wide lane.
- Both narrow half selects. A swap would overwrite the kept destination half, or would fail to clear the upper half.
- Narrow shifts of exactly 1 and exactly the narrow width. These catch off-by-one errors in lane slicing.
- The reserved size code and out-of-range immediates. These must raise the error flag with a zeroed result.
- Idle cycles. A result that does not hold would drift between strobes.

// File: rtl/vsr_pkg.sv
package vsr_pkg;

    typedef enum logic {
        OP_WIDEN  = 1'b0,
        OP_NARROW = 1'b1
    } vsr_op_e;

    localparam logic [1:0] SZ_RESERVED = 2'd3;
    localparam int         NUM_SIZES   = 3;

endpackage

// File: rtl/vsr_legal.sv
module vsr_legal
    import vsr_pkg::*;
#(
    parameter int SH_W = 7
) (
    input  vsr_op_e          op,
    input  logic [1:0]       size_code,
    input  logic [SH_W-1:0]  shamt,
    output logic             legal
);
    localparam int CW = SH_W + 1;

    logic [CW-1:0] lane_bits;
    logic [CW-1:0] sh_ext;

    always_comb begin
        lane_bits = CW'(8) << size_code;
        sh_ext    = CW'(shamt);
        if (size_code == SZ_RESERVED) begin
            legal = 1'b0;
        end else if (op == OP_WIDEN) begin
            legal = (sh_ext <= lane_bits);
        end else begin
            legal = (sh_ext != '0) && (sh_ext <= lane_bits);
        end
    end
endmodule

// File: rtl/vsr_widen.sv
module vsr_widen
    import vsr_pkg::*;
#(
    parameter int VEC_W = 128,
    parameter int SH_W  = 7
) (
    input  logic [VEC_W/2-1:0] lane_src,
    input  logic [1:0]         size_code,
    input  logic [SH_W-1:0]    shamt,
    input  logic               sext,
    output logic [VEC_W-1:0]   wide_out
);
    localparam int HALF_W = VEC_W / 2;

    logic [NUM_SIZES-1:0][VEC_W-1:0] cand;

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
        localparam int SW = 8 << k;
        localparam int LN = HALF_W / SW;
        for (genvar i = 0; i < LN; i++) begin : g_lane
            logic [SW-1:0]   piece;
            logic [2*SW-1:0] ext;
            assign piece = lane_src[i*SW +: SW];
            assign ext   = {{SW{sext & piece[SW-1]}}, piece};
            assign cand[k][i*2*SW +: 2*SW] = ext << shamt;
        end
    end

    always_comb begin
        case (size_code)
            2'd0:    wide_out = cand[0];
            2'd1:    wide_out = cand[1];
            2'd2:    wide_out = cand[2];
            default: wide_out = '0;
        endcase
    end
endmodule

// File: rtl/vsr_narrow.sv
module vsr_narrow
    import vsr_pkg::*;
#(
    parameter int VEC_W = 128,
    parameter int SH_W  = 7
) (
    input  logic [VEC_W-1:0]   src_vec,
    input  logic [1:0]         size_code,
    input  logic [SH_W-1:0]    shamt,
    output logic [VEC_W/2-1:0] half_out
);
    localparam int HALF_W = VEC_W / 2;

    logic [NUM_SIZES-1:0][HALF_W-1:0] cand;

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
        localparam int NW = 8 << k;
        localparam int LN = HALF_W / NW;
        for (genvar i = 0; i < LN; i++) begin : g_lane
            logic [2*NW-1:0] wide_lane;
            assign wide_lane = src_vec[i*2*NW +: 2*NW];
            assign cand[k][i*NW +: NW] = NW'(wide_lane >> shamt);
        end
    end

    always_comb begin
        case (size_code)
            2'd0:    half_out = cand[0];
            2'd1:    half_out = cand[1];
            2'd2:    half_out = cand[2];
            default: half_out = '0;
        endcase
    end
endmodule

// File: rtl/vec_shift_resize.sv
module vec_shift_resize
    import vsr_pkg::*;
#(
    parameter int VEC_W = 128,
    parameter int SH_W  = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 op_narrow,
    input  logic [VEC_W-1:0]     src_vec,
    input  logic [VEC_W/2-1:0]   dst_keep,
    input  logic [1:0]           size_code,
    input  logic [SH_W-1:0]      shamt,
    input  logic                 sext,
    input  logic                 half_sel,
    output logic                 out_valid,
    output logic                 out_err,
    output logic [VEC_W-1:0]     out_vec
);
    localparam int HALF_W = VEC_W / 2;

    typedef struct packed {
        logic             vld;
        logic             err;
        logic [VEC_W-1:0] res;
    } stage_t;

    stage_t st_d, st_q;

    vsr_op_e           op_sel;
    logic              legal;
    logic [HALF_W-1:0] widen_src;
    logic [VEC_W-1:0]  widen_res;
    logic [HALF_W-1:0] narrow_res;

    assign op_sel    = vsr_op_e'(op_narrow);
    assign widen_src = half_sel ? src_vec[VEC_W-1:HALF_W] : src_vec[HALF_W-1:0];

    vsr_legal #(.SH_W(SH_W)) u_legal (
        .op        (op_sel),
        .size_code (size_code),
        .shamt     (shamt),
        .legal     (legal)
    );

    vsr_widen #(.VEC_W(VEC_W), .SH_W(SH_W)) u_widen (
        .lane_src  (widen_src),
        .size_code (size_code),
        .shamt     (shamt),
        .sext      (sext),
        .wide_out  (widen_res)
    );

    vsr_narrow #(.VEC_W(VEC_W), .SH_W(SH_W)) u_narrow (
        .src_vec   (src_vec),
        .size_code (size_code),
        .shamt     (shamt),
        .half_out  (narrow_res)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.err = !legal;
            if (!legal) begin
                st_d.res = '0;
            end else if (op_sel == OP_WIDEN) begin
                st_d.res = widen_res;
            end else if (half_sel) begin
                st_d.res = {narrow_res, dst_keep};
            end else begin
                st_d.res = {{HALF_W{1'b0}}, narrow_res};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_err   = st_q.err;
    assign out_vec   = st_q.res;

    AST_STROBE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                               // R1
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_vec) && $stable(out_err)));   // R1
    AST_RESERVED_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_code == SZ_RESERVED) |=> (out_err && out_vec == '0)); // R9
    AST_UPPER_PASS_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_narrow && half_sel && legal)
            |=> (out_vec[HALF_W-1:0] == $past(dst_keep)));                     // R7
    AST_LOWER_PASS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_narrow && !half_sel) |=> (out_vec[VEC_W-1:HALF_W] == '0)); // R8
endmodule

// File: tb/test_vec_shift_resize.sv
module test_vec_shift_resize;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         op_narrow = 1'b0;
    logic [127:0] src_vec = '0;
    logic [63:0]  dst_keep = '0;
    logic [1:0]   size_code = '0;
    logic [6:0]   shamt = '0;
    logic         sext = 1'b0;
    logic         half_sel = 1'b0;
    logic         out_valid;
    logic         out_err;
    logic [127:0] out_vec;

    int n_run = 0;
    int n_fail = 0;

    logic         exp_vld = 1'b0;
    logic         exp_err = 1'b0;
    logic [127:0] exp_res = '0;
    string        exp_tag = "R1";

    always #4 clk = ~clk;

    vec_shift_resize i_vec_shift_resize (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_narrow(op_narrow),
        .src_vec(src_vec), .dst_keep(dst_keep), .size_code(size_code),
        .shamt(shamt), .sext(sext), .half_sel(half_sel),
        .out_valid(out_valid), .out_err(out_err), .out_vec(out_vec)
    );

    function automatic logic [63:0] msk(int w);
        return (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
    endfunction

    task automatic ref_model(input bit nar, input logic [127:0] s, input logic [63:0] d,
                             input int sz, input int sh, input bit sg, input bit fu,
                             output logic [127:0] r, output bit e);
        logic [63:0] half, lane, lo;
        int w, n;
        r = '0; e = 1'b0;
        if (sz == 3) begin
            e = 1'b1;
        end else begin
            w = 8 << sz;
            n = 64 / w;
            if (!nar) begin
                if (sh > w) e = 1'b1;
                else begin
                    half = fu ? s[127:64] : s[63:0];
                    for (int i = 0; i < n; i++) begin
                        lane = (half >> (i * w)) & msk(w);
                        if (sg && lane[w-1]) lane = lane | ~msk(w);
                        lane = (lane << sh) & msk(2 * w);
                        r = r | ({64'd0, lane} << (i * 2 * w));
                    end
                end
            end else begin
                if (sh < 1 || sh > w) e = 1'b1;
                else begin
                    lo = '0;
                    for (int i = 0; i < n; i++) begin
                        lane = 64'(s >> (i * 2 * w)) & msk(2 * w);
                        lane = lane >> sh;
                        lo = lo | ((lane & msk(w)) << (i * w));
                    end
                    r = fu ? {lo, d} : {64'd0, lo};
                end
            end
        end
    endtask

    task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare();
        chk(out_valid == exp_vld, "R1 valid", {127'd0, out_valid}, {127'd0, exp_vld});
        chk(out_err == exp_err, exp_tag, {127'd0, out_err}, {127'd0, exp_err});
        chk(out_vec == exp_res, exp_tag, out_vec, exp_res);
    endtask

    task automatic apply(bit v, bit nar, logic [127:0] s, logic [63:0] d,
                         int sz, int sh, bit sg, bit fu, string tag);
        logic [127:0] r;
        bit e;
        @(negedge clk);
        compare();
        in_valid  = v;
        op_narrow = nar;
        src_vec   = s;
        dst_keep  = d;
        size_code = sz[1:0];
        shamt     = sh[6:0];
        sext      = sg;
        half_sel  = fu;
        exp_vld   = v;
        if (v) begin
            ref_model(nar, s, d, sz, sh, sg, fu, r, e);
            exp_res = r;
            exp_err = e;
            if (tag == "") begin
                if (e) tag = (sz == 3) ? "R9" : "R10";
                else if (nar) tag = fu ? "R7" : "R8";
                else tag = fu ? "R3" : "R5";
            end
            exp_tag = tag;
        end else begin
            exp_tag = (tag == "") ? "R1" : tag;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [127:0] a;
        a = 128'h8172_F3E4_5D06_B7C8_19AA_2B3C_F40D_95E6;
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0 && out_err == 1'b0 && out_vec == '0, "R1 reset",
            {126'd0, out_valid, out_err} | out_vec, '0);
        rst_n = 1'b1;
        // R2 R3 R5: widen, each size, both halves
        apply(1, 0, a, 64'h0, 0, 3, 0, 0, "R2");
        apply(1, 0, a, 64'h0, 1, 5, 0, 1, "R3");
        apply(1, 0, a, 64'h0, 2, 0, 0, 0, "R2");
        // R5: shift equal to narrow width
        apply(1, 0, a, 64'h0, 1, 16, 1, 1, "R5");
        apply(1, 0, a, 64'h0, 0, 8, 0, 0, "R5");
        // R4: signed widen of negative lanes
        apply(1, 0, a, 64'h0, 0, 2, 1, 1, "R4");
        apply(1, 0, a, 64'h0, 2, 7, 1, 1, "R4");
        // R11: dst has no effect in widen
        apply(1, 0, a, 64'hFFFF_FFFF_FFFF_FFFF, 1, 4, 1, 0, "R11");
        // R6: narrow with sext toggled gives same lanes
        apply(1, 1, a, 64'h0, 0, 1, 0, 0, "R6");
        apply(1, 1, a, 64'h0, 0, 1, 1, 0, "R6");
        apply(1, 1, a, 64'h0, 2, 32, 0, 0, "R6");
        // R7 R8: narrow halves
        apply(1, 1, a, 64'h0123_4567_89AB_CDEF, 1, 9, 0, 1, "R7");
        apply(1, 1, a, 64'h0123_4567_89AB_CDEF, 1, 16, 0, 0, "R8");
        // R9: reserved size
        apply(1, 0, a, 64'h0, 3, 1, 0, 0, "R9");
        apply(1, 1, a, 64'h5, 3, 4, 0, 1, "R9");
        // R10: immediates out of range
        apply(1, 0, a, 64'h0, 1, 17, 0, 0, "R10");
        apply(1, 1, a, 64'h0, 0, 0, 0, 0, "R10");
        apply(1, 1, a, 64'h0, 0, 9, 0, 1, "R10");
        // R1: legal result then idle cycles hold
        apply(1, 1, a, 64'h77, 2, 3, 0, 1, "R1");
        apply(0, 0, '0, 64'h0, 0, 0, 0, 0, "R1");
        apply(0, 1, '1, 64'h1, 3, 0, 1, 1, "R1");
        for (int k = 0; k < 400; k++) begin
            logic [127:0] s;
            int sz, w, sh;
            s  = {$urandom, $urandom, $urandom, $urandom};
            sz = ($urandom % 8 == 0) ? 3 : int'($urandom % 3);
            w  = 8 << (sz % 3);
            sh = ($urandom % 10 == 0) ? int'($urandom % 70) : int'($urandom % (w + 1));
            apply($urandom % 4 != 0, $urandom % 2, s, {$urandom, $urandom},
                  sz, sh, $urandom % 2, $urandom % 2, "");
        end
        apply(0, 0, '0, 64'h0, 0, 0, 0, 0, "R1");
        apply(0, 0, '0, 64'h0, 0, 0, 0, 0, "R1");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule